// File: doc/BRIEF.md
# Reset and factory-default sequencer

This block turns two slow, active-low board pins and a power-good flag into a clean internal reset for a protocol controller and a single-cycle strobe that tells the configuration store to reload its factory values. Both pins pass through a synchronizer chain before any timing is applied. A pin reset takes effect only once the reset pin has stayed low for a minimum time. After that, the internal reset follows the pin and releases when the pin goes high again. While power-good is low, the internal reset is forced on.

A factory restore is requested by holding the command pin low while the supply comes up. The pin must then stay low for a long qualifying interval, timed from the moment the internal reset releases, and must then be released. The strobe fires on that release, never while the pin is still held low. It fires at most once for each power-up. All times are given in microseconds and scaled by a clocks-per-microsecond parameter.

Top module: `boot_reset_seq`

## Requirements
- R1: A low level on `rst_pin_n_i` that lasts at least RST_MIN_US*CLK_PER_US clock cycles asserts `core_rst_o`. A shorter low pulse is ignored, and `core_rst_o` stays 0 throughout and after it.
- R2: Once asserted by the pin, `core_rst_o` stays 1 for as long as `rst_pin_n_i` is low. It returns to 0 within 5 cycles after `rst_pin_n_i` goes high.
- R3: While `pwr_ok_i` is 0, `core_rst_o` is 1 whatever the pins do, and `factory_restore_o` is 0. After `pwr_ok_i` rises, `core_rst_o` stays 1 for at least SYNC_STAGES+2 cycles. With both pins high, it is 0 within 10 cycles.
- R4: A restore is armed only if `cmd_pin_n_i` is already low when power comes up. If the pin is high at power-up and is driven low afterwards, no strobe ever fires for that power-up.
- R5: After arming, `cmd_pin_n_i` must stay low for at least RESTORE_MIN_US*CLK_PER_US cycles, counted from the release of `core_rst_o`. If the pin rises earlier, no strobe fires.
- R6: After a qualifying low period, `factory_restore_o` stays 0 while the pin is still held low. It pulses within 5 cycles after `cmd_pin_n_i` rises.
- R7: `factory_restore_o` is exactly one cycle wide and fires at most once per power-up. A new power-up, meaning `pwr_ok_i` falls and then rises again, can fire it once more.
- R8: The pin low-time counter saturates and does not wrap. A reset pin held low for several times the minimum, which is longer than the counter's range, keeps `core_rst_o` at 1 for the whole time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| pwr_ok_i | input | 1 | Supply above threshold; 0 clears the block synchronously and holds reset |
| rst_pin_n_i | input | 1 | Active-low reset pin, asynchronous to clk_i |
| cmd_pin_n_i | input | 1 | Active-low command pin, asynchronous to clk_i |
| core_rst_o | output | 1 | Active-high reset to the protocol controller |
| factory_restore_o | output | 1 | One-cycle request to reload factory configuration |

## Verification
The bench builds the block with CLK_PER_US=4, RST_MIN_US=20 and RESTORE_MIN_US=500. The reset filter therefore needs 80 cycles, and the restore hold needs 2000 cycles. With these values, pulse widths one cycle either side of the reset threshold can be driven, as can a reset low time long enough to overflow an unsaturated 7-bit counter. Several complete power-up restore sequences also fit in the run, including early release, a late command and a second attempt within the same power-up.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [2:0] {
        RS_STARTUP = 3'd0,
        RS_COUNT   = 3'd1,
        RS_QUAL    = 3'd2,
        RS_FIRE    = 3'd3,
        RS_DONE    = 3'd4
    } restore_st_e;

    typedef struct packed {
        logic rst_hi;
        logic cmd_hi;
    } pin_lvl_t;

    function automatic int unsigned us_to_cycles(input int unsigned us,
                                                 input int unsigned per_us);
        return us * per_us;
    endfunction

    function automatic int unsigned startup_len(input int unsigned stages);
        return stages + 2;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i) begin
                if (clr_i) chain[g] <= RST_VAL;
                else       chain[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i) begin
                if (clr_i) chain[g] <= RST_VAL;
                else       chain[g] <= chain[g-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/low_width_filter.sv
module low_width_filter #(
    parameter int unsigned LIMIT = 20
) (
    input  logic clk_i,
    input  logic clr_i,
    input  logic lvl_i,
    output logic held_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_C  = CW'(LIMIT);
    localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          held_q;

    always_ff @(posedge clk_i) begin
        if (clr_i || lvl_i) begin
            cnt_q  <= '0;
            held_q <= 1'b0;
        end else begin
            if (cnt_q != LIM_C) cnt_q <= cnt_q + 1'b1;
            held_q <= (cnt_q >= LIM_M1);
        end
    end

    assign held_o = held_q;

    // R1: a held reset implies the pin was seen low the cycle before
    assert_held_after_low_R1: assert property (@(posedge clk_i) disable iff (clr_i)
        held_q |-> !$past(lvl_i));

    // R2: a high pin level drops the hold on the next edge
    assert_release_on_high_R2: assert property (@(posedge clk_i) disable iff (clr_i)
        lvl_i |=> !held_q);

    // R8: the low-time counter never passes its limit
    assert_cnt_saturates_R8: assert property (@(posedge clk_i) disable iff (clr_i)
        cnt_q == LIM_C && !lvl_i |=> cnt_q == LIM_C);
endmodule

// File: rtl/restore_ctrl.sv
module restore_ctrl
    import boot_seq_pkg::*;
#(
    parameter int unsigned STARTUP_CYCLES = 4,
    parameter int unsigned HOLD_CYCLES    = 2000
) (
    input  logic clk_i,
    input  logic clr_i,
    input  logic cmd_hi_i,
    input  logic pin_rst_i,
    output logic startup_o,
    output logic fire_o
);
    localparam int unsigned SW = $clog2(STARTUP_CYCLES);
    localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [SW-1:0] ST_LAST = SW'(STARTUP_CYCLES - 1);
    localparam logic [HW-1:0] HOLD_C  = HW'(HOLD_CYCLES);

    restore_st_e   st_q;
    logic [SW-1:0] st_cnt_q;
    logic [HW-1:0] hold_q;

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            st_q     <= RS_STARTUP;
            st_cnt_q <= '0;
            hold_q   <= '0;
        end else begin
            case (st_q)
                RS_STARTUP: begin
                    if (st_cnt_q == ST_LAST) st_q <= cmd_hi_i ? RS_DONE : RS_COUNT;
                    else                     st_cnt_q <= st_cnt_q + 1'b1;
                end
                RS_COUNT: begin
                    if (cmd_hi_i)              st_q   <= RS_DONE;
                    else if (pin_rst_i)        hold_q <= '0;
                    else if (hold_q == HOLD_C) st_q   <= RS_QUAL;
                    else                       hold_q <= hold_q + 1'b1;
                end
                RS_QUAL:  if (cmd_hi_i) st_q <= RS_FIRE;
                RS_FIRE:  st_q <= RS_DONE;
                default:  st_q <= RS_DONE;
            endcase
        end
    end

    assign startup_o = (st_q == RS_STARTUP);
    assign fire_o    = (st_q == RS_FIRE);

    // R6: the strobe follows the first high command level after a low one
    assert_fire_on_release_R6: assert property (@(posedge clk_i) disable iff (clr_i)
        fire_o |-> $past(cmd_hi_i) && !$past(cmd_hi_i, 2));

    // R5: qualification is reached only with the command pin still low
    assert_qual_needs_low_R5: assert property (@(posedge clk_i) disable iff (clr_i)
        $rose(st_q == RS_QUAL) |-> !$past(cmd_hi_i));
endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
    import boot_seq_pkg::*;
#(
    parameter int unsigned CLK_PER_US     = 100,
    parameter int unsigned RST_MIN_US     = 20,
    parameter int unsigned RESTORE_MIN_US = 450000,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk_i,
    input  logic pwr_ok_i,
    input  logic rst_pin_n_i,
    input  logic cmd_pin_n_i,
    output logic core_rst_o,
    output logic factory_restore_o
);
    localparam int unsigned RST_CYC  = us_to_cycles(RST_MIN_US, CLK_PER_US);
    localparam int unsigned HOLD_CYC = us_to_cycles(RESTORE_MIN_US, CLK_PER_US);
    localparam int unsigned ST_CYC   = startup_len(SYNC_STAGES);

    logic     clr;
    pin_lvl_t lvl;
    logic     pin_held;
    logic     startup;
    logic     core_rst_q;

    assign clr = !pwr_ok_i;

    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rst (
        .clk_i(clk_i), .clr_i(clr), .d_i(rst_pin_n_i), .q_o(lvl.rst_hi)
    );

    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cmd (
        .clk_i(clk_i), .clr_i(clr), .d_i(cmd_pin_n_i), .q_o(lvl.cmd_hi)
    );

    low_width_filter #(.LIMIT(RST_CYC)) u_filter (
        .clk_i(clk_i), .clr_i(clr), .lvl_i(lvl.rst_hi), .held_o(pin_held)
    );

    restore_ctrl #(.STARTUP_CYCLES(ST_CYC), .HOLD_CYCLES(HOLD_CYC)) u_restore (
        .clk_i(clk_i), .clr_i(clr), .cmd_hi_i(lvl.cmd_hi),
        .pin_rst_i(pin_held), .startup_o(startup), .fire_o(factory_restore_o)
    );

    always_ff @(posedge clk_i) begin
        if (clr) core_rst_q <= 1'b1;
        else     core_rst_q <= startup | pin_held;
    end

    assign core_rst_o = core_rst_q;

    // R7: the restore strobe lasts a single cycle
    assert_strobe_one_cycle_R7: assert property (@(posedge clk_i) disable iff (clr)
        factory_restore_o |=> !factory_restore_o);

    // R2: a qualified pin reset reaches the core output one edge later
    assert_held_drives_core_R2: assert property (@(posedge clk_i) disable iff (clr)
        pin_held |=> core_rst_o);

    // R3: during the start-up window the core stays in reset
    assert_startup_reset_R3: assert property (@(posedge clk_i) disable iff (clr)
        startup |=> core_rst_o);
endmodule

// File: tb/test_boot_reset_seq.sv
`timescale 1ns/1ps
module test_boot_reset_seq;
    localparam int unsigned CPU   = 4;
    localparam int unsigned RMIN  = 20;
    localparam int unsigned HMIN  = 500;
    localparam int unsigned LIM   = CPU * RMIN;
    localparam int unsigned HCYC  = CPU * HMIN;
    localparam int NV = 6;
    localparam int unsigned VEC_W [NV] = '{1, 5, LIM - 1, LIM, LIM + 1, 3 * LIM};
    localparam bit          VEC_E [NV] = '{0, 0, 0, 1, 1, 1};

    logic clk = 1'b0;
    logic pwr_ok = 1'b0;
    logic rst_n = 1'b1;
    logic cmd_n = 1'b1;
    logic core_rst, restore;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int run_w  = 0;
    int max_w  = 0;
    int rst_seen = 0;
    int base;

    always #5 clk = ~clk;

    boot_reset_seq #(
        .CLK_PER_US(CPU), .RST_MIN_US(RMIN), .RESTORE_MIN_US(HMIN), .SYNC_STAGES(2)
    ) i_boot_reset_seq (
        .clk_i(clk), .pwr_ok_i(pwr_ok), .rst_pin_n_i(rst_n), .cmd_pin_n_i(cmd_n),
        .core_rst_o(core_rst), .factory_restore_o(restore)
    );

    always @(negedge clk) begin
        if (restore) begin
            if (run_w == 0) pulses = pulses + 1;
            run_w = run_w + 1;
            if (run_w > max_w) max_w = run_w;
        end else begin
            run_w = 0;
        end
        if (core_rst) rst_seen = rst_seen + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic power_cycle(input logic cmd_lvl);
        pwr_ok = 1'b0;
        tick(4);
        cmd_n = cmd_lvl;
        pwr_ok = 1'b1;
        tick(12);
    endtask

    initial begin
        tick(5);
        chk("R3 reset state core_rst", core_rst, 1);
        chk("R3 reset state restore", restore, 0);
        rst_n = 1'b0;
        tick(LIM + 5);
        chk("R3 pin ignored while power low", core_rst, 1);
        rst_n = 1'b1;
        pwr_ok = 1'b1;
        tick(2);
        chk("R3 startup hold", core_rst, 1);
        tick(8);
        chk("R3 release after startup", core_rst, 0);

        for (int i = 0; i < NV; i++) begin
            base = rst_seen;
            rst_n = 1'b0;
            tick(VEC_W[i]);
            if (VEC_W[i] > LIM + 5) chk("R2 R8 held while pin low", core_rst, 1);
            rst_n = 1'b1;
            tick(5);
            chk("R2 release after pin high", core_rst, 0);
            tick(5);
            chk(VEC_E[i] ? "R1 long pulse asserts" : "R1 short pulse ignored",
                (rst_seen > base) ? 1 : 0, VEC_E[i]);
        end

        pwr_ok = 1'b0;
        tick(3);
        chk("R3 power drop forces reset", core_rst, 1);

        base = pulses;
        power_cycle(1'b0);
        tick(HCYC + 300);
        chk("R6 no strobe while held low", pulses - base, 0);
        cmd_n = 1'b1;
        tick(8);
        chk("R6 strobe on release", pulses - base, 1);
        chk("R7 strobe width", max_w, 1);
        cmd_n = 1'b0;
        tick(HCYC + 300);
        cmd_n = 1'b1;
        tick(8);
        chk("R7 once per power-up", pulses - base, 1);

        base = pulses;
        power_cycle(1'b0);
        tick(HCYC - 200);
        cmd_n = 1'b1;
        tick(20);
        chk("R5 early release no strobe", pulses - base, 0);

        base = pulses;
        power_cycle(1'b1);
        cmd_n = 1'b0;
        tick(HCYC + 300);
        cmd_n = 1'b1;
        tick(20);
        chk("R4 late command not armed", pulses - base, 0);

        base = pulses;
        power_cycle(1'b0);
        tick(HCYC + 100);
        cmd_n = 1'b1;
        tick(8);
        chk("R7 new power-up restores again", pulses - base, 1);
        chk("R7 strobe width again", max_w, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule